// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a small 32-bit processor core. It executes a subset of six instructions, one per clock: register add, add-immediate, word load, word store, branch-if-equal and absolute jump. Every instruction finishes in the cycle in which it is fetched. The core holds its own program counter, a 32-entry register file, an add/subtract unit, and separate instruction and data word arrays. A combinational decoder turns each instruction word into eight control signals. These signals steer the operand, destination and write-back muxes and gate the register and memory writes.

The instruction array is filled through a load port, normally while reset is held. After reset is released, the core runs from address zero. On every cycle it shows the current program counter and its register-write request (enable, destination and data), so that an outside model can follow it cycle by cycle.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears every register. Instruction fields are taken as opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0].
- R2: Opcode 0x00 with function 0x20 writes rs+rt (modulo 2^32) to register rd, and the next PC is PC+4.
- R3: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate [15:0] to register rt.
- R4: Opcode 0x23 writes to rt the data word at byte address rs+sign-extended immediate. The word index is the address bits above bit 1, taken modulo the data depth.
- R5: Opcode 0x2B stores the rt value at byte address rs+sign-extended immediate and requests no register write.
- R6: Opcode 0x04 requests no write. When rs equals rt, the next PC is PC+4+(sign-extended immediate << 2); otherwise it is PC+4.
- R7: Opcode 0x02 sets the next PC to {4'b0000, instr[25:0], 2'b00} and writes nothing.
- R8: Any other encoding, including opcode 0x00 with a function other than 0x20, writes nothing and advances the PC by 4.
- R9: Register 0 reads as zero on both read ports. A write request that targets it leaves it at zero.
- R10: The two read ports are independent. An add that uses the same register for rs and rt reads the same value on both ports.
- R11: Each clock outside reset retires exactly one instruction. The fetched word is the one written through the load port at index PC[7:2], taken modulo the instruction depth.
- R12: Immediates with bit 15 set are sign-extended, both in the arithmetic and in the address and branch offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write strobe for the instruction array |
| load_addr | input | $clog2(IMEM_DEPTH) | Word index written by the load port |
| load_data | input | 32 | Instruction word to store |
| pc_o | output | 32 | Program counter of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write requested by the current instruction |
| rf_waddr_o | output | 5 | Destination register of the request |
| rf_wdata_o | output | 32 | Data of the request |

## Verification
The bench builds the core with its default 64-word instruction and data arrays. At this size the program counter wraps within the instruction index bits, which makes it possible to jump to the top 26-bit target and to check that the upper nibble is forced to zero and that the fetch index wraps. The 64-word data array leaves room for positive and negative load/store offsets. A behavioural model tracks the registers, data words and PC. It compares the PC and the write request on every clock through a hand-assembled program. The program covers forward, backward and not-taken branches, writes to register 0, undefined encodings and a store followed by a load.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREGS  = 1 << REG_AW;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_JUMP    = 6'h02;
    localparam logic [5:0] OPC_BEQ     = 6'h04;
    localparam logic [5:0] OPC_ADDI    = 6'h08;
    localparam logic [5:0] OPC_LOAD    = 6'h23;
    localparam logic [5:0] OPC_STORE   = 6'h2B;
    localparam logic [5:0] FN_ADD      = 6'h20;

    typedef struct packed {
        logic [5:0]        opcode;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } insn_fields_t;

    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_SUB = 1'b1
    } alu_op_e;

    // Eight datapath steering signals
    typedef struct packed {
        logic    branch;
        logic    jump;
        logic    b_imm;
        alu_op_e alu_op;
        logic    mem_we;
        logic    reg_we;
        logic    dst_rt;
        logic    wb_mem;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [25:0] t);
        return {4'b0000, t, 2'b00};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output ctrl_t             ctrl,
    output logic [REG_AW-1:0] rs_a,
    output logic [REG_AW-1:0] rt_a,
    output logic [REG_AW-1:0] wr_a,
    output logic [XLEN-1:0]   imm_sx,
    output logic [25:0]       imm26
);
    insn_fields_t f;
    assign f = insn_fields_t'(instr);

    logic [4:0] unused_shamt;
    assign unused_shamt = f.shamt;

    always_comb begin
        ctrl = '0;
        case (f.opcode)
            OPC_SPECIAL: begin
                if (f.funct == FN_ADD) begin
                    ctrl.reg_we = 1'b1;
                end
            end
            OPC_ADDI: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst_rt = 1'b1;
                ctrl.b_imm  = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst_rt = 1'b1;
                ctrl.b_imm  = 1'b1;
                ctrl.wb_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_imm  = 1'b1;
                ctrl.mem_we = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: begin
                ctrl = '0;
            end
        endcase
    end

    assign rs_a   = f.rs;
    assign rt_a   = f.rt;
    assign wr_a   = ctrl.dst_rt ? f.rt : f.rd;
    assign imm_sx = sext16(instr[15:0]);
    assign imm26  = instr[25:0];

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_core_pkg::*;
#(
    parameter int DEPTH = NREGS,
    parameter int WIDTH = XLEN,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    ra1,
    input  logic [AW-1:0]    ra2,
    output logic [WIDTH-1:0] rd1,
    output logic [WIDTH-1:0] rd2,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);
    logic [WIDTH-1:0] regs [DEPTH];

    // Entry 0 is never written, so it stays at its reset value
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

    a_r9_zero_read: assert property (@(posedge clk) disable iff (rst)
        ((ra1 == '0) |-> (rd1 == '0)) and ((ra2 == '0) |-> (rd2 == '0)));

    a_r9_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && (wa == '0)) |=> (regs[0] == '0));

    a_r10_same_port: assert property (@(posedge clk) disable iff (rst)
        (ra1 == ra2) |-> (rd1 == rd2));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] y,
    output logic             zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem
    import sc_core_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] words [DEPTH];
    logic [AW-1:0]   idx;

    assign idx = addr[AW+1:2];

    logic [XLEN-1:0] unused_addr;
    assign unused_addr = addr;

    always_ff @(posedge clk) begin
        if (we) begin
            words[idx] <= wdata;
        end
    end

    assign rdata = words[idx];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_en,
    input  logic [$clog2(IMEM_DEPTH)-1:0] load_addr,
    input  logic [31:0]                   load_data,
    output logic [31:0]                   pc_o,
    output logic                          rf_we_o,
    output logic [4:0]                    rf_waddr_o,
    output logic [31:0]                   rf_wdata_o
);
    localparam int IA_W = $clog2(IMEM_DEPTH);

    logic [XLEN-1:0] imem [IMEM_DEPTH];
    logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_dest;
    logic [XLEN-1:0] instr;

    ctrl_t             ctrl;
    logic [REG_AW-1:0] rs_a, rt_a, wr_a;
    logic [XLEN-1:0]   imm_sx;
    logic [25:0]       imm26;
    logic [XLEN-1:0]   rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
    logic              alu_zero;

    // Fetch
    always_ff @(posedge clk) begin
        if (load_en) begin
            imem[load_addr] <= load_data;
        end
    end

    assign instr = imem[pc_q[IA_W+1:2]];

    logic [XLEN-1:0] unused_pc;
    assign unused_pc = pc_q;

    // Decode
    sc_decode u_dec (
        .instr  (instr),
        .ctrl   (ctrl),
        .rs_a   (rs_a),
        .rt_a   (rt_a),
        .wr_a   (wr_a),
        .imm_sx (imm_sx),
        .imm26  (imm26)
    );

    sc_regfile #(.DEPTH(NREGS), .WIDTH(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (rs_a),
        .ra2 (rt_a),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (ctrl.reg_we),
        .wa  (wr_a),
        .wd  (wb_data)
    );

    // Execute
    assign alu_b = ctrl.b_imm ? imm_sx : rt_val;

    sc_alu #(.WIDTH(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Memory
    sc_dmem #(.DEPTH(DMEM_DEPTH)) u_dm (
        .clk   (clk),
        .we    (ctrl.mem_we),
        .addr  (alu_y),
        .wdata (rt_val),
        .rdata (dm_rdata)
    );

    assign wb_data = ctrl.wb_mem ? dm_rdata : alu_y;

    // Next PC
    assign pc_plus4 = pc_q + 32'd4;
    assign br_dest  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};

    always_comb begin
        if (ctrl.jump) begin
            pc_d = jump_dest(imm26);
        end else if (ctrl.branch && alu_zero) begin
            pc_d = br_dest;
        end else begin
            pc_d = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = ctrl.reg_we;
    assign rf_waddr_o = wr_a;
    assign rf_wdata_o = wb_data;

    a_r11_sequential: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.jump && !ctrl.branch) |=> (pc_q == $past(pc_q) + 32'd4));

    a_r6_taken: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && (rs_val == rt_val)) |=>
            (pc_q == $past(pc_q + 32'd4 + {imm_sx[XLEN-3:0], 2'b00})));

    a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && (rs_val != rt_val)) |=> (pc_q == $past(pc_q) + 32'd4));

    a_r7_jump: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (pc_q == {4'b0000, $past(instr[25:0]), 2'b00}));

    a_r5_store_no_reg: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_STORE) |-> !rf_we_o);

endmodule

// File: tb/test_sc_core.sv
module test_sc_core;

    localparam int IMEM_DEPTH = 64;
    localparam int DMEM_DEPTH = 64;
    localparam int IA_W       = $clog2(IMEM_DEPTH);
    localparam int RUN_CYCLES = 70;

    logic            clk = 1'b0;
    logic            rst;
    logic            load_en;
    logic [IA_W-1:0] load_addr;
    logic [31:0]     load_data;
    logic [31:0]     pc_o;
    logic            rf_we_o;
    logic [4:0]      rf_waddr_o;
    logic [31:0]     rf_wdata_o;

    always #5 clk = ~clk;

    sc_core #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) i_sc_core (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_addr  (load_addr),
        .load_data  (load_data),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] prog [IMEM_DEPTH];
    logic [31:0] m_reg [32];
    logic [31:0] m_dm [DMEM_DEPTH];
    logic [31:0] m_pc;

    function automatic logic [31:0] enc_r(int rd, int rs, int rt, int fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rt, int rs, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] t);
        return {6'h02, t};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (pc %h)", tag, what, act, exp, m_pc);
        end
    endtask

    // Compares the current cycle against the model, then advances the model
    task automatic model_cycle();
        logic [31:0] ins, sx, a, b, addr, nxt, wd;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, wa;
        logic        we;
        string       tag, pc_tag;
        ins  = prog[(m_pc >> 2) % IMEM_DEPTH];
        op   = ins[31:26];
        rs   = ins[25:21];
        rt   = ins[20:16];
        rd   = ins[15:11];
        fn   = ins[5:0];
        sx   = {{16{ins[15]}}, ins[15:0]};
        a    = (rs == 0) ? 32'd0 : m_reg[rs];
        b    = (rt == 0) ? 32'd0 : m_reg[rt];
        addr = a + sx;
        nxt  = m_pc + 32'd4;
        we   = 1'b0;
        wa   = 5'd0;
        wd   = 32'd0;
        tag  = "R8";
        pc_tag = "R11";
        if (op == 6'h00 && fn == 6'h20) begin
            we = 1'b1; wa = rd; wd = a + b;
            tag = (rs == rt) ? "R10" : "R2";
        end else if (op == 6'h08) begin
            we = 1'b1; wa = rt; wd = addr;
            tag = ins[15] ? "R12" : "R3";
        end else if (op == 6'h23) begin
            we = 1'b1; wa = rt; wd = m_dm[(addr >> 2) % DMEM_DEPTH];
            tag = ins[15] ? "R12" : "R4";
        end else if (op == 6'h2B) begin
            tag = "R5";
        end else if (op == 6'h04) begin
            tag = "R6"; pc_tag = "R6";
            if (a == b) nxt = m_pc + 32'd4 + {sx[29:0], 2'b00};
        end else if (op == 6'h02) begin
            tag = "R7"; pc_tag = "R7";
            nxt = {4'b0000, ins[25:0], 2'b00};
        end else begin
            pc_tag = "R8";
        end
        if (we && (wa == 0 || rs == 0)) tag = "R9";

        check(pc_tag, "pc", pc_o, m_pc);
        check(tag, "write enable", {31'd0, rf_we_o}, {31'd0, we});
        if (we) begin
            check(tag, "write address", {27'd0, rf_waddr_o}, {27'd0, wa});
            check(tag, "write data", rf_wdata_o, wd);
        end

        if (we && wa != 0) m_reg[wa] = wd;
        if (op == 6'h2B) m_dm[(addr >> 2) % DMEM_DEPTH] = b;
        m_pc = nxt;
    endtask

    initial begin
        for (int i = 0; i < IMEM_DEPTH; i++) prog[i] = 32'd0;
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        for (int i = 0; i < DMEM_DEPTH; i++) m_dm[i] = 32'd0;

        prog[0]  = enc_i(8'h08, 1, 0, 5);
        prog[1]  = enc_i(8'h08, 2, 0, -3);
        prog[2]  = enc_r(3, 1, 2, 8'h20);
        prog[3]  = enc_r(4, 3, 3, 8'h20);
        prog[4]  = enc_i(8'h2B, 1, 4, 8);
        prog[5]  = enc_i(8'h23, 5, 0, 12);
        prog[6]  = enc_i(8'h08, 0, 1, 7);
        prog[7]  = enc_r(6, 0, 1, 8'h20);
        prog[8]  = enc_i(8'h04, 5, 1, 2);
        prog[9]  = enc_i(8'h08, 7, 0, 99);
        prog[10] = enc_i(8'h08, 7, 0, 98);
        prog[11] = enc_i(8'h04, 2, 1, 5);
        prog[12] = 32'hFC00_0000;
        prog[13] = enc_r(7, 1, 1, 8'h22);
        prog[14] = enc_i(8'h2B, 2, 0, 0);
        prog[15] = enc_i(8'h23, 9, 4, -4);
        prog[16] = enc_i(8'h08, 13, 0, 3);
        prog[17] = enc_j(26'd20);
        prog[18] = enc_i(8'h08, 10, 0, 1);
        prog[19] = enc_i(8'h08, 10, 0, 1);
        prog[20] = enc_i(8'h08, 11, 11, 1);
        prog[21] = enc_i(8'h04, 13, 11, 1);
        prog[22] = enc_i(8'h04, 0, 0, -3);
        prog[23] = enc_r(14, 9, 2, 8'h20);
        prog[24] = enc_i(8'h08, 15, 0, 16'h7FFF);
        prog[25] = enc_r(15, 15, 15, 8'h20);
        prog[26] = enc_i(8'h23, 16, 0, 12);
        prog[27] = enc_j(26'h3FF_FFFF);
        prog[30] = enc_j(26'd30);
        prog[63] = enc_j(26'd30);

        rst       = 1'b1;
        load_en   = 1'b0;
        load_addr = '0;
        load_data = '0;
        for (int i = 0; i < IMEM_DEPTH; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = IA_W'(i);
            load_data = prog[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        #1;
        check("R1", "pc in reset", pc_o, 32'd0);
        rst  = 1'b0;
        m_pc = 32'd0;
        #1;
        // R1: first fetch after reset is word 0
        check("R1", "first write address", {27'd0, rf_waddr_o}, 32'd1);
        for (int c = 0; c < RUN_CYCLES; c++) begin
            model_cycle();
            @(negedge clk);
            #1;
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule